// File: doc/BRIEF.md
# Local Interrupt Timer with Absolute Deadline Mode

This block is a per-core interrupt timer. A free-running 64-bit timestamp is fed in from outside, and the block raises a one-cycle interrupt request that carries a programmed vector. A two-bit mode field in the timer control register selects one of three kinds of operation. In one-shot mode a down-counter fires once. In periodic mode the down-counter reloads and fires again each time it expires. In deadline mode the block fires when the timestamp reaches a programmed absolute value.

Software reaches four registers through a single-cycle port made of valid, write, address and data. Writes take effect at the clock edge where they are presented. Reads are combinational from the address. Which registers are visible depends on the current mode, and a change of mode disarms the timer.

Top module: `lvt_timer`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low. The control register layout is: vector in bits [7:0], mode in bits [9:8], mask in bit 12. The address map is: 0 control, 1 initial count, 2 current count (read-only), 3 deadline.
- R2: When the mode is 11 (reserved), reads of the initial count and the current count return zero, and a write to the initial count is ignored and produces no interrupt.
- R3: When the mode is not 10 (deadline), a read of the deadline returns zero, and a write to the deadline is ignored and produces no interrupt.
- R4: In deadline mode, a written value above the current timestamp is stored and reads back unchanged. The interrupt fires at the first edge where the sampled timestamp is at or above that value. For a value D written while the timestamp is T, the pulse is visible in the (D-T+1)th cycle after the write.
- R5: When a deadline expires, the stored deadline becomes zero.
- R6: In deadline mode, a nonzero written value at or below the current timestamp (equality included) fires in the cycle right after the write, and the deadline reads back zero.
- R7: In deadline mode, writing zero disarms a pending deadline, so no interrupt follows and the deadline reads zero.
- R8: In one-shot mode (00), writing an initial count N loads the current count with N. The current count then decrements every cycle, one pulse appears in the (N+1)th cycle after the write, and the count stays at zero afterwards.
- R9: In periodic mode (01), an initial count N produces its first pulse in the (N+1)th cycle after the write and a further pulse every N cycles after that.
- R10: Writing an initial count of zero stops a running countdown, and no pulse follows.
- R11: A control write that changes the mode disarms the timer and clears the initial count, the current count and the deadline. A control write that keeps the mode changes only the vector and the mask, and a running countdown continues.
- R12: While the mask bit is set, an expiry still updates the timer state (the deadline is cleared), but the interrupt output stays low.
- R13: The interrupt vector output equals the vector field of the most recent control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tsc | input | 64 | Free-running timestamp, sampled each edge |
| req_valid | input | 1 | Register access valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select |
| req_wdata | input | 64 | Write data |
| rd_data | output | 64 | Combinational read data for req_addr |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
The assertions assume that the timestamp never decreases and that at most one register write is presented in each cycle. The bench drives the timestamp as a counter that increments at every rising edge. It places writes on falling edges, one per cycle. It computes deadlines from the timestamp value it sees when it issues the write. The bench never issues a mode-changing control write in the same cycle as an expiry it is checking, because the block gives that write priority and suppresses the pulse.

// File: rtl/lvt_timer.sv
module lvt_timer #(
  parameter int TS_W  = 64,
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  tsc,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_addr,
  input  logic [TS_W-1:0]  req_wdata,
  output logic [TS_W-1:0]  rd_data,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int MODE_LO  = VEC_W;
  localparam int MASK_BIT = VEC_W + 4;
  localparam logic [1:0] M_ONE = 2'b00, M_PER = 2'b01, M_DL = 2'b10;
  localparam logic [1:0] A_CTRL = 2'd0, A_ICNT = 2'd1, A_CCNT = 2'd2, A_DL = 2'd3;

  logic [VEC_W-1:0] vec_q;
  logic             mask_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] icnt_q, ccnt_q;
  logic             run_q;
  logic [TS_W-1:0]  dl_q;

  wire is_cnt  = (mode_q == M_ONE) || (mode_q == M_PER);
  wire is_dl   = (mode_q == M_DL);
  wire wr      = req_valid && req_write;
  wire wr_ctrl = wr && (req_addr == A_CTRL);
  wire wr_icnt = wr && (req_addr == A_ICNT) && is_cnt;
  wire wr_dl   = wr && (req_addr == A_DL) && is_dl;
  wire [1:0] new_mode = req_wdata[MODE_LO +: 2];
  wire mode_chg = wr_ctrl && (new_mode != mode_q);

  wire cnt_hit = run_q && (ccnt_q == CNT_W'(1)) && !wr_icnt;
  wire dl_hit  = is_dl && (dl_q != '0) && (tsc >= dl_q) && !wr_dl;
  wire dl_now  = wr_dl && (req_wdata != '0) && (req_wdata <= tsc);
  wire fire    = (cnt_hit || dl_hit || dl_now) && !mode_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q     <= '0;
      mask_q    <= 1'b0;
      mode_q    <= M_ONE;
      icnt_q    <= '0;
      ccnt_q    <= '0;
      run_q     <= 1'b0;
      dl_q      <= '0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= fire && !mask_q;
      if (mode_chg) begin
        icnt_q <= '0;
        ccnt_q <= '0;
        run_q  <= 1'b0;
        dl_q   <= '0;
      end else begin
        if (wr_icnt) begin
          icnt_q <= req_wdata[CNT_W-1:0];
          ccnt_q <= req_wdata[CNT_W-1:0];
          run_q  <= (req_wdata[CNT_W-1:0] != '0);
        end else if (run_q) begin
          if (ccnt_q == CNT_W'(1)) begin
            if (mode_q == M_PER) ccnt_q <= icnt_q;
            else begin
              ccnt_q <= '0;
              run_q  <= 1'b0;
            end
          end else begin
            ccnt_q <= ccnt_q - CNT_W'(1);
          end
        end
        if (wr_dl) dl_q <= (req_wdata > tsc) ? req_wdata : '0;
        else if (dl_hit) dl_q <= '0;
      end
      if (wr_ctrl) begin
        vec_q  <= req_wdata[VEC_W-1:0];
        mask_q <= req_wdata[MASK_BIT];
        mode_q <= new_mode;
      end
    end
  end

  assign irq_vector = vec_q;

  always_comb begin
    rd_data = '0;
    case (req_addr)
      A_CTRL: begin
        rd_data[VEC_W-1:0]    = vec_q;
        rd_data[MODE_LO +: 2] = mode_q;
        rd_data[MASK_BIT]     = mask_q;
      end
      A_ICNT: if (is_cnt) rd_data[CNT_W-1:0] = icnt_q;
      A_CCNT: if (is_cnt) rd_data[CNT_W-1:0] = ccnt_q;
      default: if (is_dl) rd_data = dl_q;
    endcase
  end
endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
  parameter int TS_W  = 64,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [1:0]       req_addr,
  input logic [1:0]       wr_mode,
  input logic [1:0]       mode_q,
  input logic             mask_q,
  input logic [CNT_W-1:0] icnt_q,
  input logic [CNT_W-1:0] ccnt_q,
  input logic [TS_W-1:0]  dl_q,
  input logic [TS_W-1:0]  rd_data,
  input logic             irq_pulse
);
  // R11: mode change clears all timer state
  a_r11_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd0 && wr_mode != mode_q)
    |=> (icnt_q == '0 && ccnt_q == '0 && dl_q == '0));

  // R5: a pulse in deadline mode leaves the deadline cleared
  a_r5_dl_cleared_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && mode_q == 2'b10) |-> (dl_q == '0));

  // R12: no pulse from an expiry taken while masked
  a_r12_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(mask_q));

  // R8: an expired one-shot stays at zero
  a_r8_oneshot_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 && ccnt_q == '0 && !(req_valid && req_write && req_addr == 2'd1))
    |=> (ccnt_q == '0));

  // R3: deadline hidden outside deadline mode
  a_r3_dl_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b10 && req_addr == 2'd3) |-> (rd_data == '0));

  // R2: counts hidden in the reserved mode
  a_r2_cnt_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11 && (req_addr == 2'd1 || req_addr == 2'd2)) |-> (rd_data == '0));
endmodule

bind lvt_timer lvt_timer_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .wr_mode(req_wdata[MODE_LO +: 2]), .mode_q(mode_q),
  .mask_q(mask_q), .icnt_q(icnt_q), .ccnt_q(ccnt_q), .dl_q(dl_q),
  .rd_data(rd_data), .irq_pulse(irq_pulse)
);

// File: tb/test_lvt_timer.sv
`timescale 1ns/1ps
module test_lvt_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] tsc;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = 2'd0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data;
  logic irq_pulse;
  logic [7:0] irq_vector;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (!rst_n) tsc <= 64'd1000; else tsc <= tsc + 64'd1;

  lvt_timer i_lvt_timer (.clk(clk), .rst_n(rst_n), .tsc(tsc), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector));

  function automatic logic [63:0] ctrl(input logic [1:0] mode, input logic mask, input logic [7:0] vec);
    return (64'(mode) << 8) | (64'(mask) << 12) | 64'(vec);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    req_addr = a; #1; d = rd_data;
  endtask

  task automatic first_irq(input int maxk, output int k);
    k = 0;
    for (int i = 1; i <= maxk; i++) begin
      if (irq_pulse && k == 0) k = i;
      if (k == 0) @(negedge clk);
    end
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (irq_pulse) c++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", d, 64'd0);
    end
    chk("R1 reset irq", 64'(irq_pulse), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_oneshot();
    logic [63:0] d; int k, c;
    wr(2'd0, ctrl(2'b00, 1'b0, 8'h31));
    wr(2'd1, 64'd4);
    rd(2'd2, d); chk("R8 ccount load", d, 64'd4);
    first_irq(10, k); chk("R8 oneshot cycle", 64'(k), 64'd5);
    chk("R13 vector oneshot", 64'(irq_vector), 64'h31);
    @(negedge clk);
    count_irq(20, c); chk("R8 single pulse", 64'(c), 64'd0);
    rd(2'd2, d); chk("R8 ccount zero", d, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_periodic();
    logic [63:0] d; int k, c;
    wr(2'd0, ctrl(2'b01, 1'b0, 8'h40));
    wr(2'd1, 64'd3);
    first_irq(10, k); chk("R9 first pulse", 64'(k), 64'd4);
    @(negedge clk);
    count_irq(9, c); chk("R9 repeat pulses", 64'(c), 64'd3);
    wr(2'd0, ctrl(2'b01, 1'b0, 8'h55));
    rd(2'd1, d); chk("R11 same mode keeps icount", d, 64'd3);
    first_irq(5, k); chk("R11 countdown continues", 64'(k != 0), 64'd1);
    chk("R13 vector updated", 64'(irq_vector), 64'h55);
    @(negedge clk);
    wr(2'd0, ctrl(2'b00, 1'b0, 8'h55));
    rd(2'd1, d); chk("R11 mode change icount", d, 64'd0);
    rd(2'd2, d); chk("R11 mode change ccount", d, 64'd0);
    count_irq(12, c); chk("R11 disarmed", 64'(c), 64'd0);
  endtask

  task automatic t_zero_icnt();
    logic [63:0] d; int c;
    wr(2'd1, 64'd6);
    wr(2'd1, 64'd0);
    count_irq(15, c); chk("R10 zero stops", 64'(c), 64'd0);
    rd(2'd2, d); chk("R10 ccount", d, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_reserved();
    logic [63:0] d; int c;
    wr(2'd0, ctrl(2'b11, 1'b0, 8'h11));
    wr(2'd1, 64'd5);
    rd(2'd1, d); chk("R2 icount hidden", d, 64'd0);
    rd(2'd2, d); chk("R2 ccount hidden", d, 64'd0);
    count_irq(10, c); chk("R2 write ignored", 64'(c), 64'd0);
  endtask

  task automatic t_dl_gated();
    logic [63:0] d; int c;
    wr(2'd0, ctrl(2'b00, 1'b0, 8'h11));
    wr(2'd3, tsc + 64'd3);
    rd(2'd3, d); chk("R3 dl hidden", d, 64'd0);
    count_irq(10, c); chk("R3 dl write ignored", 64'(c), 64'd0);
    wr(2'd0, ctrl(2'b10, 1'b0, 8'h22));
    rd(2'd3, d); chk("R3 dl not stored", d, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_dl_future();
    logic [63:0] d, dv; int k;
    dv = tsc + 64'd6;
    wr(2'd3, dv);
    rd(2'd3, d); chk("R4 dl readback", d, dv);
    first_irq(20, k); chk("R4 dl fire cycle", 64'(k), 64'd7);
    chk("R13 vector dl", 64'(irq_vector), 64'h22);
    rd(2'd3, d); chk("R5 dl cleared", d, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_dl_past();
    logic [63:0] d; int k;
    wr(2'd3, tsc - 64'd5);
    rd(2'd3, d); chk("R6 past reads zero", d, 64'd0);
    first_irq(3, k); chk("R6 past immediate", 64'(k), 64'd1);
    @(negedge clk);
    wr(2'd3, tsc);
    first_irq(3, k); chk("R6 equal immediate", 64'(k), 64'd1);
    @(negedge clk);
  endtask

  task automatic t_dl_zero();
    logic [63:0] d; int c;
    wr(2'd3, tsc + 64'd10);
    wr(2'd3, 64'd0);
    count_irq(20, c); chk("R7 zero disarms", 64'(c), 64'd0);
    rd(2'd3, d); chk("R7 dl zero", d, 64'd0);
    @(negedge clk);
  endtask

  task automatic t_mask();
    logic [63:0] d; int c, k;
    wr(2'd0, ctrl(2'b10, 1'b1, 8'h22));
    wr(2'd3, tsc + 64'd4);
    count_irq(12, c); chk("R12 masked no irq", 64'(c), 64'd0);
    rd(2'd3, d); chk("R12 state updated", d, 64'd0);
    @(negedge clk);
    wr(2'd0, ctrl(2'b10, 1'b0, 8'h22));
    wr(2'd3, 64'd1);
    first_irq(3, k); chk("R12 unmasked fires", 64'(k), 64'd1);
    @(negedge clk);
  endtask

  task automatic t_mode_clear_dl();
    logic [63:0] d; int c;
    wr(2'd3, tsc + 64'd30);
    wr(2'd0, ctrl(2'b00, 1'b0, 8'h22));
    count_irq(40, c); chk("R11 dl disarmed", 64'(c), 64'd0);
    wr(2'd0, ctrl(2'b10, 1'b0, 8'h22));
    rd(2'd3, d); chk("R11 dl cleared", d, 64'd0);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_periodic();
    t_zero_icnt();
    t_reserved();
    t_dl_gated();
    t_dl_future();
    t_dl_past();
    t_dl_zero();
    t_mask();
    t_mode_clear_dl();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule